// File: doc/BRIEF.md
# Video Interrupt Status Controller

This block keeps the interrupt status, interrupt enable and per-signal lock words of a video timing core and drives a single interrupt line toward the host. Its inputs come from the surrounding timing logic as levels or single-cycle pulses. These are the generator's active-video and vertical-blank outputs, the detector's active-video and vertical-blank inputs, six per-signal lock flags with their detection enables, and sixteen frame-sync pulses. The block turns the level inputs into one-shot events. Detector events count only while the detector is locked. Gaining lock and losing lock each set their own sticky bit.

Software reaches the block through a plain word-wide write/read port with a two-bit word address. Status and error bits are set by hardware. Software clears a bit by writing a 1 to it, and hardware setting a bit wins over a clear in the same cycle. The interrupt line is a registered OR over every status bit whose enable bit is set.

Top module: `vid_irq_ctrl`

## Requirements
- R1: Status bits 31:16 are sticky: frame-sync pulse n (n = 0..15) sets status bit 16+n in the cycle the pulse is high.
- R2: Status bit 13 is set on a rising edge of generator active video, and bit 12 on a rising edge of generator vertical blank. A level held high does not set the bit again after it is cleared.
- R3: Status bit 11 (detector active video) and bit 10 (detector vertical blank) are set on a rising edge of the matching input only while the live lock state is 1. An edge that occurs before lock is not recorded later.
- R4: The live lock state is 1 when at least one detection enable is 1 and every enabled lock flag is 1. Status bit 8 is set when the live lock state goes from 0 to 1. Lock flags of disabled signals are ignored.
- R5: Status bit 9 is set when a lock flag whose detection enable is 1 goes from 1 to 0. A disabled signal losing lock has no effect.
- R6: Error bits 21..16 map to lock flags 5..0: chroma (21), active video (20), hsync (19), vsync (18), hblank (17), vblank (16). A bit is set in every cycle that its flag and its enable are both 1, and it stays set after the flag drops.
- R7: Writing 1 to a status or error bit clears it. Writing 0 leaves a bit unchanged.
- R8: If hardware sets a bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R9: The enable word shares the status layout. Only bits 31:16 and 13:8 are writable, and all other bits read 0.
- R10: The interrupt output is 1 exactly one cycle after some bit is 1 in both status and enable, and it is 0 one cycle after no such bit remains.
- R11: The timing word (address 3) shows the live lock state in bit 0, unlatched. Status bit 8 stays set after lock is lost.
- R12: After reset, all status, enable and error bits, the interrupt output and the read data are 0.
- R13: The word addresses are 0 status, 1 enable, 2 error and 3 timing. Read data is registered and shows the addressed word one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_active_i | input | 1 | Generator active video level |
| gen_vblank_i | input | 1 | Generator vertical blank level |
| det_active_i | input | 1 | Detector active video level |
| det_vblank_i | input | 1 | Detector vertical blank level |
| lock_flag_i | input | 6 | Per-signal lock flags (5 chroma .. 0 vblank) |
| det_en_i | input | 6 | Per-signal detection enables |
| fsync_i | input | 16 | Frame-sync pulses |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest situation to reach is a detector edge that happens before lock and must stay unrecorded after lock arrives. A close second is the mix of enabled and disabled lock flags, where a disabled flag must neither block lock nor raise loss. The stimulus holds detector active video high while the lock flags are still low, then completes lock and clears the lock event, and expects a zero status word. A later low-high toggle must then set the bit. For the lock flags, the enable mask is changed while the flags stay steady, so that a disabled flag can drop without a loss event.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int FSYNC_N = 16;
  localparam int LOCK_N  = 6;
  localparam int ADDR_W  = 2;

  // software-visible bit positions
  localparam int FS_LSB     = DATA_W - FSYNC_N;
  localparam int B_GEN_ACT  = 13;
  localparam int B_GEN_VBL  = 12;
  localparam int B_DET_ACT  = 11;
  localparam int B_DET_VBL  = 10;
  localparam int B_LOSS     = 9;
  localparam int B_LOCK     = 8;
  localparam int ERR_LSB    = 16;

  localparam logic [DATA_W-1:0] STAT_MASK = {{FSYNC_N{1'b1}}, 2'b00, 6'h3F, 8'h00};
  localparam logic [DATA_W-1:0] ERR_MASK  =
    {{(DATA_W-ERR_LSB-LOCK_N){1'b0}}, {LOCK_N{1'b1}}, {ERR_LSB{1'b0}}};

  typedef enum logic [ADDR_W-1:0] {
    WA_STATUS = 2'd0,
    WA_ENABLE = 2'd1,
    WA_ERROR  = 2'd2,
    WA_TIMING = 2'd3
  } word_addr_e;
endpackage

// File: rtl/vid_irq_edge.sv
module vid_irq_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/vid_irq_lock_mon.sv
module vid_irq_lock_mon #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lock_i,
  input  logic [N-1:0] en_i,
  output logic         live_o,
  output logic         gain_o,
  output logic         loss_o,
  output logic [N-1:0] err_set_o
);
  logic [N-1:0] lock_q;
  logic         live_q;
  logic [N-1:0] dropped;

  assign live_o    = (|en_i) && ((lock_i | ~en_i) == {N{1'b1}});
  assign dropped   = lock_q & ~lock_i & en_i;
  assign gain_o    = live_o & ~live_q;
  assign loss_o    = |dropped;
  assign err_set_o = lock_i & en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
      live_q <= 1'b0;
    end else begin
      lock_q <= lock_i;
      live_q <= live_o;
    end
  end

  // R4 R5
  gain_loss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gain_o && loss_o));
endmodule

// File: rtl/vid_irq_w1c.sv
module vid_irq_w1c #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] clr;

  assign clr = clr_wr_i ? clr_data_i : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((q & ~clr) | set_i) & MASK;
  end

  assign q_o = q;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((set_i & MASK) != '0) |=> ((q_o & $past(set_i & MASK)) == $past(set_i & MASK)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_wr_i && set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vid_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               gen_active_i,
  input  logic               gen_vblank_i,
  input  logic               det_active_i,
  input  logic               det_vblank_i,
  input  logic [LOCK_N-1:0]  lock_flag_i,
  input  logic [LOCK_N-1:0]  det_en_i,
  input  logic [FSYNC_N-1:0] fsync_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [1:0]        gen_rise, det_rise;
  logic              live, gain, loss;
  logic [LOCK_N-1:0] err_bits;
  logic [DATA_W-1:0] stat_set, err_set;
  logic [DATA_W-1:0] status_q, error_q, enable_q;
  logic              wr_stat, wr_err, wr_enab;

  vid_irq_edge #(.W(2)) gen_edge_i (
    .clk(clk), .rst(rst),
    .lvl_i({gen_active_i, gen_vblank_i}), .rise_o(gen_rise));

  vid_irq_edge #(.W(2)) det_edge_i (
    .clk(clk), .rst(rst),
    .lvl_i({det_active_i, det_vblank_i}), .rise_o(det_rise));

  vid_irq_lock_mon #(.N(LOCK_N)) lock_i (
    .clk(clk), .rst(rst), .lock_i(lock_flag_i), .en_i(det_en_i),
    .live_o(live), .gain_o(gain), .loss_o(loss), .err_set_o(err_bits));

  always_comb begin
    stat_set = '0;
    stat_set[DATA_W-1:FS_LSB] = fsync_i;
    stat_set[B_GEN_ACT] = gen_rise[1];
    stat_set[B_GEN_VBL] = gen_rise[0];
    stat_set[B_DET_ACT] = det_rise[1] & live;
    stat_set[B_DET_VBL] = det_rise[0] & live;
    stat_set[B_LOSS]    = loss;
    stat_set[B_LOCK]    = gain;
    err_set = '0;
    err_set[ERR_LSB +: LOCK_N] = err_bits;
  end

  assign wr_stat = wr_en_i && (addr_i == WA_STATUS);
  assign wr_err  = wr_en_i && (addr_i == WA_ERROR);
  assign wr_enab = wr_en_i && (addr_i == WA_ENABLE);

  vid_irq_w1c #(.W(DATA_W), .MASK(STAT_MASK)) status_reg_i (
    .clk(clk), .rst(rst), .set_i(stat_set), .clr_wr_i(wr_stat),
    .clr_data_i(wdata_i), .q_o(status_q));

  vid_irq_w1c #(.W(DATA_W), .MASK(ERR_MASK)) error_reg_i (
    .clk(clk), .rst(rst), .set_i(err_set), .clr_wr_i(wr_err),
    .clr_data_i(wdata_i), .q_o(error_q));

  always_ff @(posedge clk) begin
    if (rst) enable_q <= '0;
    else if (wr_enab) enable_q <= wdata_i & STAT_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= |(status_q & enable_q);
      case (addr_i)
        WA_STATUS: rdata_o <= status_q;
        WA_ENABLE: rdata_o <= enable_q;
        WA_ERROR:  rdata_o <= error_q;
        default:   rdata_o <= {{(DATA_W-1){1'b0}}, live};
      endcase
    end
  end

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_q == '0) |=> !irq_o);

  // R3
  det_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_set[B_DET_ACT] || stat_set[B_DET_VBL]) |-> live);

  // R9
  enable_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    wr_enab |=> ((enable_q & ~STAT_MASK) == '0));
endmodule

// File: tb/vid_irq_ctrl_tb_top.sv
module vid_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gav = 0, gvb = 0, dav = 0, dvb = 0;
  logic [5:0]  lock = '0, en = '0;
  logic [15:0] fs = '0;
  logic        wr = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  vid_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .gen_active_i(gav), .gen_vblank_i(gvb),
    .det_active_i(dav), .det_vblank_i(dvb), .lock_flag_i(lock),
    .det_en_i(en), .fsync_i(fs), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // {lock, en, gav, gvb, dav, dvb, fsync, expected status}
  localparam logic [63:0] VEC [10] = '{
    {6'h00, 6'h00, 4'b0000, 16'h0001, 32'h0001_0000},
    {6'h00, 6'h00, 4'b0000, 16'h8000, 32'h8000_0000},
    {6'h00, 6'h00, 4'b1000, 16'h0000, 32'h0000_2000},
    {6'h00, 6'h00, 4'b0100, 16'h0000, 32'h0000_1000},
    {6'h3F, 6'h3F, 4'b0010, 16'h0000, 32'h0000_0800},
    {6'h3F, 6'h3F, 4'b0001, 16'h0000, 32'h0000_0400},
    {6'h00, 6'h3F, 4'b0010, 16'h0000, 32'h0000_0000},
    {6'h01, 6'h01, 4'b0010, 16'h0000, 32'h0000_0800},
    {6'h00, 6'h00, 4'b1000, 16'hA5A5, 32'hA5A5_2000},
    {6'h3F, 6'h00, 4'b0010, 16'h0000, 32'h0000_0000}
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_word(input logic [1:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    tick();
    wr = 0;
  endtask

  task automatic rd_word(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    tick(2);
    d = rdata;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    tick(3);
    rst = 0;
    // R12 reset state
    chk("R12 irq", {31'b0, irq}, 32'h0);
    rd_word(2'd0, r); chk("R12 status", r, 32'h0);
    rd_word(2'd1, r); chk("R12 enable", r, 32'h0);
    rd_word(2'd2, r); chk("R12 error", r, 32'h0);
    rd_word(2'd3, r); chk("R12 timing", r, 32'h0);

    // table walk: R1 R2 R3 R4
    foreach (VEC[i]) begin
      lock = VEC[i][63:58]; en = VEC[i][57:52];
      tick(2);
      wr_word(2'd0, 32'hFFFF_FFFF);
      {gav, gvb, dav, dvb} = VEC[i][51:48];
      fs = VEC[i][47:32];
      tick();
      {gav, gvb, dav, dvb} = 4'b0; fs = '0;
      rd_word(2'd0, r);
      chk($sformatf("R1/R2/R3 vector %0d", i), r, VEC[i][31:0]);
    end

    // R2 held level does not re-set
    lock = 0; en = 0; tick(2);
    gav = 1; tick(2);
    wr_word(2'd0, 32'hFFFF_FFFF);
    tick(2);
    rd_word(2'd0, r); chk("R2 held level", r, 32'h0);
    gav = 0; tick(); gav = 1; tick(); gav = 0;
    rd_word(2'd0, r); chk("R2 new edge", r, 32'h2000);

    // R3 edge before lock is not recorded
    en = 6'h3F; lock = 0; tick(2);
    dav = 1; tick(2);
    lock = 6'h3F; tick(2);
    wr_word(2'd0, 32'hFFFF_FFFF);
    rd_word(2'd0, r); chk("R3 pre-lock edge", r, 32'h0);
    dav = 0; tick(); dav = 1; tick(); dav = 0;
    rd_word(2'd0, r); chk("R3 post-lock edge", r, 32'h0800);

    // R4 lock gain only when all enabled flags high
    lock = 0; tick(2); wr_word(2'd0, 32'hFFFF_FFFF);
    lock = 6'h1F; tick(2);
    rd_word(2'd0, r); chk("R4 partial lock", r, 32'h0);
    lock = 6'h3F; tick();
    rd_word(2'd0, r); chk("R4 full lock", r, 32'h0100);
    wr_word(2'd0, 32'hFFFF_FFFF);
    // R5 enabled drop
    lock = 6'h3E; tick();
    rd_word(2'd0, r); chk("R5 enabled loss", r, 32'h0200);
    // R4 disabled flag ignored
    en = 6'h3E; tick(2);
    rd_word(2'd0, r); chk("R4 disabled ignored", r, 32'h0300);
    lock = 6'h3F; tick(2);
    wr_word(2'd0, 32'hFFFF_FFFF);
    // R5 disabled drop gives no loss
    lock = 6'h3E; tick(2);
    rd_word(2'd0, r); chk("R5 disabled drop", r, 32'h0);
    // R11 live lock word and sticky status
    rd_word(2'd3, r); chk("R11 timing live", r, 32'h1);
    lock = 6'h00; tick();
    rd_word(2'd3, r); chk("R11 timing drop", r, 32'h0);
    en = 6'h3F; lock = 6'h3F; tick(2);
    wr_word(2'd0, 32'hFFFF_FFFF);
    en = 6'h3F; lock = 6'h00; tick(2);
    rd_word(2'd0, r); chk("R11 lock bit sticky", r, 32'h0200);
    lock = 6'h3F; tick(); lock = 6'h00; tick();
    rd_word(2'd0, r); chk("R11 lock stays after loss", r, 32'h0300);

    // R6 error bits
    wr_word(2'd2, 32'hFFFF_FFFF);
    lock = 6'h21; tick(); lock = 6'h00;
    rd_word(2'd2, r); chk("R6 error map", r, 32'h0021_0000);
    // R7 clear and write-0
    wr_word(2'd2, 32'h0020_0000);
    rd_word(2'd2, r); chk("R7 w1c error", r, 32'h0001_0000);
    wr_word(2'd2, 32'h0000_0000);
    rd_word(2'd2, r); chk("R7 write zero", r, 32'h0001_0000);
    wr_word(2'd0, 32'hFFFF_FFFF);
    wr_word(2'd0, 32'h0);
    rd_word(2'd0, r); chk("R7 status cleared", r, 32'h0);

    // R8 set beats clear
    en = 6'h01; lock = 6'h01; tick();
    wr_word(2'd2, 32'hFFFF_FFFF);
    rd_word(2'd2, r); chk("R8 error set wins", r, 32'h0001_0000);
    lock = 0; en = 0; tick(2);
    wr_word(2'd0, 32'hFFFF_FFFF);
    fs = 16'h0001; wr_word(2'd0, 32'hFFFF_FFFF); fs = '0;
    rd_word(2'd0, r); chk("R8 status set wins", r, 32'h0001_0000);
    wr_word(2'd0, 32'hFFFF_FFFF);

    // R9 enable layout
    wr_word(2'd1, 32'hFFFF_FFFF);
    rd_word(2'd1, r); chk("R9 enable mask", r, 32'hFFFF_3F00);

    // R10 irq timing
    wr_word(2'd1, 32'h0000_2000);
    tick(2);
    gav = 1; tick(); gav = 0;
    chk("R10 irq not yet", {31'b0, irq}, 32'h0);
    tick();
    chk("R10 irq raised", {31'b0, irq}, 32'h1);
    wr_word(2'd1, 32'h0000_1000);
    chk("R10 irq before mask", {31'b0, irq}, 32'h1);
    tick();
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr_word(2'd1, 32'h0000_2000);
    tick();
    chk("R10 irq unmasked", {31'b0, irq}, 32'h1);
    wr_word(2'd0, 32'h0000_2000);
    tick();
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);

    // R13 read latency
    addr = 2'd1; tick();
    chk("R13 read latency", rdata, 32'h0000_2000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule